// File: doc/BRIEF.md
# Unified Signedness Array Multiplier

This block multiplies two 32-bit operands and returns the full 64-bit product together with a selected 32-bit word. One two-bit mode input tells the block how to read each operand: as unsigned or as two's complement. Bit 1 of the mode describes operand A, the multiplicand, and bit 0 describes operand B, the multiplier. The `sel_hi` input chooses which half of the product appears on `result`. With these two controls the one block yields the low-word multiply and the three high-word multiplies of a RISC-V core: signed×signed, unsigned×unsigned and signed×unsigned.

There is only one partial-product array. Row i is operand A gated by bit i of B, shifted left by i places, and all rows are formed in parallel. For a signed operand the array complements the cross terms that involve that operand's sign bit, and a single constant row carries the correction that this needs. This is the Baugh-Wooley approach. All rows then feed one adder tree. The full product and the word select are held in one output register, so the result appears one clock after the inputs are sampled.

Top module: `mul_unified`

## Requirements
- R1: With mode 2'b00, `product` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R2: With mode 2'b11, `product` equals the 64-bit two's-complement product of `op_a` and `op_b`, both read as signed.
- R3: With mode 2'b10, `product` equals signed `op_a` times unsigned `op_b`, taken modulo 2^64.
- R4: With mode 2'b01, `product` equals unsigned `op_a` times signed `op_b`, taken modulo 2^64.
- R5: For the same operands, `product[31:0]` is the same in every mode and equals the low 32 bits of the unsigned product.
- R6: `result` is `product[63:32]` when `sel_hi` is 1 and `product[31:0]` when `sel_hi` is 0.
- R7: `product` and `result` show the operands, mode and `sel_hi` that were sampled at the previous rising edge of `clk`. They do not change between edges.
- R8: While `rst_n` is low, `product` and `result` are zero. Reset takes effect asynchronously, and its release is synchronised to `clk`.
- R9: Extreme operands give exact results. Any carry out of bit 63 is dropped. Examples: signed 0x80000000×0x80000000 is 0x4000000000000000, signed (-1)×(-1) is 1, and mixed (-1)×0xFFFFFFFF is 0xFFFFFFFF00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | Multiplicand; signed when mode[1] is 1 |
| op_b | input | 32 | Multiplier; signed when mode[0] is 1 |
| mode | input | 2 | Operand signedness: bit 1 for A, bit 0 for B |
| sel_hi | input | 1 | 1 selects the high word for `result`, 0 the low word |
| product | output | 64 | Registered full product |
| result | output | 32 | Registered selected word of the product |

## Verification
The hardest case to reach is where the complemented sign-row terms and the correction constant must carry all the way to bit 63 and then out of the word. This happens when both sign bits are set and most cross terms are ones, as in 0x80000000 and 0xFFFFFFFF paired under each mode. A single random pattern almost never lands exactly on these extremes. The stimulus therefore walks a fixed table of such operand pairs through all four modes and both word selects. Random pairs follow, to exercise the middle rows. Directed cases then cover latency and an asynchronous reset taken in the middle of the run.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int unsigned MUL_W = 32;

  typedef enum logic [1:0] {
    MODE_UU = 2'b00,
    MODE_US = 2'b01,
    MODE_SU = 2'b10,
    MODE_SS = 2'b11
  } mul_mode_e;

  function automatic logic a_is_signed(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic b_is_signed(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
  parameter int unsigned N = 32,
  localparam int unsigned PW = 2 * N,
  localparam int unsigned ROWS = N + 1
) (
  input  logic [N-1:0]            op_a,
  input  logic [N-1:0]            op_b,
  input  logic                    sgn_a,
  input  logic                    sgn_b,
  output logic [ROWS-1:0][PW-1:0] rows
);

  // One row per multiplier bit; a cross term is complemented when exactly
  // one of its factors is the sign bit of an operand read as signed.
  for (genvar i = 0; i < N; i++) begin : g_row
    logic row_sign_b;
    assign row_sign_b = (i == N - 1) && sgn_b;

    always_comb begin
      rows[i] = '0;
      for (int j = 0; j < N; j++) begin
        rows[i][i+j] = (op_a[j] & op_b[i]) ^ (((j == N - 1) && sgn_a) ^ row_sign_b);
      end
    end
  end

  // Correction row: minus the sum of the weights of all complemented terms.
  // Both signed: weights 2^(N-1)..2^(2N-3) twice  -> 2^N + 2^(2N-1).
  // One signed:  weights 2^(N-1)..2^(2N-2) once   -> 2^(N-1) + 2^(2N-1).
  always_comb begin
    rows[N] = '0;
    if (sgn_a ^ sgn_b) begin
      rows[N][N-1]  = 1'b1;
      rows[N][PW-1] = 1'b1;
    end else if (sgn_a && sgn_b) begin
      rows[N][N]    = 1'b1;
      rows[N][PW-1] = 1'b1;
    end
  end

endmodule

// File: rtl/mul_sum_tree.sv
module mul_sum_tree #(
  parameter int unsigned W    = 64,
  parameter int unsigned ROWS = 33,
  localparam int unsigned LEAVES = 2 ** $clog2(ROWS)
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sum
);

  // Heap-ordered binary tree: node k sums nodes 2k and 2k+1.
  logic [W-1:0] node [1:2*LEAVES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < ROWS) begin : g_used
      assign node[LEAVES+k] = rows[k];
    end else begin : g_pad
      assign node[LEAVES+k] = '0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_add
    assign node[k] = node[2*k] + node[2*k+1];
  end

  assign sum = node[1];

endmodule

// File: rtl/mul_unified.sv
module mul_unified
  import mul_pkg::*;
#(
  parameter int unsigned N       = MUL_W,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PW   = 2 * N,
  localparam int unsigned ROWS = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  input  logic [1:0]    mode,
  input  logic          sel_hi,
  output logic [PW-1:0] product,
  output logic [N-1:0]  result
);

  logic                    rst_sync_n;
  logic [ROWS-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]           sum_full;
  logic [N-1:0]            word_nxt;

  mul_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mul_pp_gen #(.N(N)) u_pp (
    .op_a  (op_a),
    .op_b  (op_b),
    .sgn_a (a_is_signed(mode)),
    .sgn_b (b_is_signed(mode)),
    .rows  (pp_rows)
  );

  mul_sum_tree #(.W(PW), .ROWS(ROWS)) u_tree (
    .rows (pp_rows),
    .sum  (sum_full)
  );

  always_comb begin
    word_nxt = sel_hi ? sum_full[PW-1:N] : sum_full[N-1:0];
  end

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    logic [N-1:0]  word_q;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        prod_q <= '0;
        word_q <= '0;
      end else begin
        prod_q <= sum_full;
        word_q <= word_nxt;
      end
    end

    assign product = prod_q;
    assign result  = word_q;
  end else begin : g_comb
    assign product = sum_full;
    assign result  = word_nxt;
  end

endmodule

// File: rtl/mul_unified_chk.sv
module mul_unified_chk #(
  parameter int unsigned N       = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PW = 2 * N
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [N-1:0]  op_a,
  input logic [N-1:0]  op_b,
  input logic [1:0]    mode,
  input logic          sel_hi,
  input logic [PW-1:0] product,
  input logic [N-1:0]  result
);

  logic [N-1:0] a_s, b_s;
  logic [1:0]   m_s;
  logic         h_s;

  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        a_s <= '0;
        b_s <= '0;
        m_s <= '0;
        h_s <= 1'b0;
      end else begin
        a_s <= op_a;
        b_s <= op_b;
        m_s <= mode;
        h_s <= sel_hi;
      end
    end
  end else begin : g_pass
    assign a_s = op_a;
    assign b_s = op_b;
    assign m_s = mode;
    assign h_s = sel_hi;
  end

  logic [PW-1:0] a_u, b_u, a_x, b_x;
  assign a_u = {{N{1'b0}}, a_s};
  assign b_u = {{N{1'b0}}, b_s};
  assign a_x = {{N{a_s[N-1]}}, a_s};
  assign b_x = {{N{b_s[N-1]}}, b_s};

  logic [PW-1:0] ref_uu, ref_ss, ref_su, ref_us;
  assign ref_uu = a_u * b_u;
  assign ref_ss = a_x * b_x;
  assign ref_su = a_x * b_u;
  assign ref_us = a_u * b_x;

  assert_unsigned_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_s == 2'b00) |-> (product == ref_uu));

  assert_signed_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_s == 2'b11) |-> (product == ref_ss));

  assert_mixed_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_s == 2'b10) |-> (product == ref_su));

  assert_mixed_rev_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_s == 2'b01) |-> (product == ref_us));

  assert_low_word_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    product[N-1:0] == ref_uu[N-1:0]);

  assert_word_sel_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    result == (h_s ? product[PW-1:N] : product[N-1:0]));

endmodule

bind mul_unified mul_unified_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .mode       (mode),
  .sel_hi     (sel_hi),
  .product    (product),
  .result     (result)
);

// File: tb/sim_mul_unified.sv
module sim_mul_unified;

  localparam int NV = 10;
  localparam logic [31:0] VA [NV] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                                      32'h80000000, 32'h7FFFFFFF, 32'h1, 32'hFFFFFFFF, 32'h12345678};
  localparam logic [31:0] VB [NV] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                                      32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h9ABCDEF0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [1:0]  mode;
  logic        sel_hi;
  logic [63:0] product;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mul_unified u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .mode(mode), .sel_hi(sel_hi), .product(product), .result(result)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] x, input logic [31:0] y,
                                           input logic [1:0] m);
    logic [63:0] xe, ye;
    xe = m[1] ? {{32{x[31]}}, x} : {32'h0, x};
    ye = m[0] ? {{32{y[31]}}, y} : {32'h0, y};
    return xe * ye;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b11:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, check at next falling edge.
  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m,
                       input logic h);
    logic [63:0] e;
    op_a = x; op_b = y; mode = m; sel_hi = h;
    e = ref_prod(x, y, m);
    @(negedge clk);
    check64(mode_tag(m), product, e);
    check64("R6", {32'h0, result}, {32'h0, h ? e[63:32] : e[31:0]});
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] lows [4];
    logic [63:0] prev;
    rst_n = 1'b0; op_a = '0; op_b = '0; mode = 2'b00; sel_hi = 1'b0;
    repeat (3) @(negedge clk);
    check64("R8", product, 64'h0);
    check64("R8", {32'h0, result}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: every mode, both word selects.
    for (int v = 0; v < NV; v++) begin
      for (int m = 0; m < 4; m++) begin
        apply(VA[v], VB[v], 2'(m), 1'b0);
        lows[m] = product;
        apply(VA[v], VB[v], 2'(m), 1'b1);
      end
      for (int m = 1; m < 4; m++)
        check64("R5", {32'h0, lows[m][31:0]}, {32'h0, lows[0][31:0]});
    end

    // Random operands across all modes.
    for (int r = 0; r < 40; r++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      apply(x, y, 2'(r % 4), r[2]);
    end

    // R9: extreme operands, carry out of bit 63 dropped.
    apply(32'h80000000, 32'h80000000, 2'b11, 1'b1);
    check64("R9", product, 64'h4000000000000000);
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11, 1'b0);
    check64("R9", product, 64'h1);
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 1'b1);
    check64("R9", product, 64'hFFFFFFFF00000001);
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00, 1'b1);
    check64("R9", product, 64'hFFFFFFFE00000001);

    // R7: output holds until the next rising edge.
    prev = product;
    op_a = 32'h00010000; op_b = 32'h00010000; mode = 2'b00;
    #5;
    check64("R7", product, prev);
    @(negedge clk);
    check64("R7", product, 64'h0000000100000000);

    // R8: asynchronous reset mid-run.
    op_a = 32'h12345678; op_b = 32'h87654321; mode = 2'b11; sel_hi = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check64("R8", product, 64'h0);
    check64("R8", {32'h0, result}, 64'h0);
    @(negedge clk);
    op_a = '0; op_b = '0; mode = 2'b00; sel_hi = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(32'h12345678, 32'h87654321, 2'b11, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule